// File: doc/BRIEF.md
# Reverse-Linked List Clear Engine

This engine prepares a table of empty list heads in memory. Software loads a top address and a word count, then writes one specific control value. The engine then walks downward from the top address, one 32-bit word at a time. Each word it writes holds the address of the word just beneath it, so the table becomes a chain that runs from the top entry down to the bottom one. The bottom word is written with an all-ones 24-bit end-of-chain marker instead of a link.

Writes leave through a simple request/ready memory port: a word is transferred on a clock edge where both `mem_req` and `mem_ready` are high. When the end marker has been accepted, the engine clears the trigger and start bits of its control register, raises `done` for one cycle and goes idle. Addresses are 24 bits wide and wrap modulo 2^24.

Top module: `list_chain_fill`

## Requirements
- R1: After reset, the address, counter and control registers read 0, and `mem_req` and `done` are low.
- R2: The register port decodes `reg_sel`: 0 is the top address, which keeps the low 24 bits and reads the upper 8 bits as zero; 1 is the 32-bit counter; 2 is the 32-bit control word; 3 reads zero. `reg_rdata` follows `reg_sel` without a clock delay, and a write takes effect on the edge where `reg_wr_en` is high.
- R3: A fill starts only when the control register holds exactly 0x11000002 and no fill is running. Any other control value is stored and produces no memory request.
- R4: The number of words written equals bits 15:0 of the counter, with 0 meaning 65536. Bits 31:16 are ignored.
- R5: The k-th accepted write (k starting at 0) goes to address (top − 4k) mod 2^24. Every write except the last carries (its own address − 4) mod 2^24, zero-extended to 32 bits.
- R6: The last write carries 0x00FFFFFF. With a count of 1, the only write is this marker, at the top address.
- R7: While `mem_ready` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values, and the address does not advance.
- R8: `done` is high for exactly one cycle, namely the cycle after the edge that accepts the end marker. `mem_req` is low from that cycle on.
- R9: On completion, control bits 28 and 24 are cleared, so a started value of 0x11000002 reads back as 0x00000002, and no new fill starts.
- R10: Register writes that arrive while a fill is running, including on the edge that accepts the end marker, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 address, 1 counter, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the word on this edge |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can coincide on one edge: software rewriting the control register with the start value, and the engine accepting its end marker and clearing that same register. The bench provokes this by holding a start write on the register port for every edge of a fill while memory is always ready. The last edge of that window is the one that accepts the marker. The collision is judged correct when the control word reads 0x00000002 afterwards, `done` pulses once, and no further memory request appears, which shows that completion wins and the late write is dropped.

// File: rtl/chain_fill_pkg.sv
package chain_fill_pkg;

  localparam int CTRL_W = 32;

  // exact control word that launches a fill
  localparam logic [CTRL_W-1:0] START_CODE = 32'h1100_0002;
  // trigger (bit 28) and start (bit 24) cleared on completion
  localparam logic [CTRL_W-1:0] CLEAR_MASK = 32'h1100_0000;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/cf_regs.sv
module cf_regs
  import chain_fill_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              finish,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  cnt_field,
  output logic              launch
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_ok;

  // writes are dropped for the whole run, completion edge included
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else if (finish) begin
      ctrl_q <= ctrl_q & ~DATA_W'(CLEAR_MASK);
    end else if (wr_ok) begin
      case (reg_sel_e'(sel))
        SEL_ADDR:  addr_q <= wdata[ADDR_W-1:0];
        SEL_COUNT: cnt_q  <= wdata;
        SEL_CTRL:  ctrl_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sel))
      SEL_ADDR:  rdata = DATA_W'(addr_q);
      SEL_COUNT: rdata = cnt_q;
      SEL_CTRL:  rdata = ctrl_q;
      default:   rdata = '0;
    endcase
  end

  assign base_addr = addr_q;
  assign cnt_field = cnt_q[CNT_W-1:0];
  assign launch    = (ctrl_q == DATA_W'(START_CODE)) && !busy;

  p_clear_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (ctrl_q[28] == 1'b0) && (ctrl_q[24] == 1'b0));

  p_launch_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctrl_q) == DATA_W'(START_CODE)));

  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(cnt_q));

endmodule

// File: rtl/cf_seq.sv
module cf_seq #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  cnt_field,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              finish,
  output logic              done
);

  localparam int TOT_W = CNT_W + 1;

  // zero in the count field stands for the full 2^CNT_W words
  function automatic logic [TOT_W-1:0] word_total(input logic [CNT_W-1:0] c);
    if (c == '0) return TOT_W'(1) << CNT_W;
    return TOT_W'(c);
  endfunction

  // address of the word below, modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] link_below(input logic [ADDR_W-1:0] a);
    return a - ADDR_W'(4);
  endfunction

  function automatic logic [DATA_W-1:0] end_marker();
    return DATA_W'({ADDR_W{1'b1}});
  endfunction

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [TOT_W-1:0]  left_q;
  logic              done_q;
  logic              accept;
  logic              last_word;

  assign last_word = (left_q == TOT_W'(1));
  assign accept    = busy_q && mem_ready;
  assign finish    = accept && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (launch) begin
        busy_q <= 1'b1;
        cur_q  <= base_addr;
        left_q <= word_total(cnt_field);
      end else if (accept) begin
        if (last_word) begin
          busy_q <= 1'b0;
        end else begin
          cur_q  <= link_below(cur_q);
          left_q <= left_q - TOT_W'(1);
        end
      end
    end
  end

  assign mem_req   = busy_q;
  assign mem_addr  = cur_q;
  assign mem_wdata = last_word ? end_marker() : DATA_W'(link_below(cur_q));
  assign busy      = busy_q;
  assign done      = done_q;

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_word) |=> (mem_addr == $past(mem_addr) - ADDR_W'(4)));

  p_first_at_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> mem_req && (mem_addr == $past(base_addr)));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && !mem_req);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/list_chain_fill.sv
module list_chain_fill #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              done
);

  logic              launch;
  logic              busy;
  logic              finish;
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  cnt_field;

  cf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .busy      (busy),
    .finish    (finish),
    .rdata     (reg_rdata),
    .base_addr (base_addr),
    .cnt_field (cnt_field),
    .launch    (launch)
  );

  cf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .base_addr (base_addr),
    .cnt_field (cnt_field),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .finish    (finish),
    .done      (done)
  );

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

// File: tb/list_chain_fill_test.sv
module list_chain_fill_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic        done;

  int checks = 0;
  int failures = 0;

  // job model
  logic [23:0] exp_start = 24'd0;
  int          exp_total = 0;
  int          idx = 0;
  bit          in_job = 1'b0;
  bit          exp_done = 1'b0;
  bit          done_seen = 1'b0;
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          hold_pending = 1'b0;
  logic [23:0] hold_addr = 24'd0;
  logic [31:0] hold_data = 32'd0;

  always #10 clk = ~clk;

  list_chain_fill uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and output monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic        nr;
      logic [23:0] ea;
      logic [31:0] ed;
      check(done === exp_done, "R8 done", 32'(done), 32'(exp_done));
      if (exp_done) begin
        check(!mem_req, "R8 req after done", 32'(mem_req), 32'd0);
        done_seen = 1'b1;
      end
      exp_done = 1'b0;
      if (hold_pending)
        check(mem_req && mem_addr == hold_addr && mem_wdata == hold_data,
              "R7 stall hold", {8'd0, mem_addr}, {8'd0, hold_addr});
      if (mem_req && !in_job)
        check(1'b0, "R3 unexpected request", {8'd0, mem_addr}, 32'd0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0:       nr = 1'b1;
        1:       nr = ~mem_ready;
        default: nr = lfsr[0];
      endcase
      mem_ready = nr;
      hold_pending = mem_req && !nr;
      hold_addr = mem_addr;
      hold_data = mem_wdata;
      if (mem_req && nr && in_job) begin
        if (idx >= exp_total) begin
          check(1'b0, "R4 extra write", 32'(idx), 32'(exp_total));
        end else begin
          ea = exp_start - 24'(4 * idx);
          ed = (idx == exp_total - 1) ? 32'h00FF_FFFF : {8'd0, ea - 24'd4};
          check(mem_addr == ea, "R5 address", {8'd0, mem_addr}, {8'd0, ea});
          check(mem_wdata == ed, (idx == exp_total - 1) ? "R6 marker" : "R5 link",
                mem_wdata, ed);
          if (idx == exp_total - 1) exp_done = 1'b1;
        end
        idx++;
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic arm(input logic [23:0] start, input logic [31:0] cnt, input int mode);
    rdy_mode = mode;
    exp_start = start;
    exp_total = (cnt[15:0] == 16'd0) ? 65536 : int'(cnt[15:0]);
    idx = 0;
    done_seen = 1'b0;
    in_job = 1'b1;
  endtask

  task automatic finish_job(input logic [23:0] start, input logic [31:0] cnt);
    logic [31:0] v;
    while (!done_seen) @(negedge clk);
    check(idx == exp_total, "R4 word count", 32'(idx), 32'(exp_total));
    repeat (2) @(negedge clk);
    in_job = 1'b0;
    rd(2'd2, v);
    check(v == 32'h0000_0002, "R9 control after done", v, 32'h0000_0002);
    rd(2'd0, v);
    check(v == {8'd0, start}, "R10 address kept", v, {8'd0, start});
    rd(2'd1, v);
    check(v == cnt, "R10 counter kept", v, cnt);
    repeat (6) @(negedge clk);
    check(!mem_req, "R9 no relaunch", 32'(mem_req), 32'd0);
  endtask

  task automatic run_fill(input logic [23:0] start, input logic [31:0] cnt, input int mode);
    wr(2'd0, {8'hA5, start});
    wr(2'd1, cnt);
    arm(start, cnt, mode);
    wr(2'd2, 32'h1100_0002);
    finish_job(start, cnt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bad [4];
    bad[0] = 32'h0100_0002; bad[1] = 32'h1100_0000;
    bad[2] = 32'h1100_0003; bad[3] = 32'h1000_0002;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req && !done, "R1 outputs", {30'd0, mem_req, done}, 32'd0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check(v == 32'd0, "R1 register", v, 32'd0);
    end

    // R2 decode and masking
    wr(2'd0, 32'hAB12_3456);
    rd(2'd0, v);
    check(v == 32'h0012_3456, "R2 address width", v, 32'h0012_3456);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v);
    check(v == 32'd0, "R2 unused select", v, 32'd0);
    wr(2'd1, 32'h0003_0002);
    rd(2'd1, v);
    check(v == 32'h0003_0002, "R2 counter", v, 32'h0003_0002);

    // R3 near-miss control values store but never start
    for (int b = 0; b < 4; b++) begin
      wr(2'd2, bad[b]);
      repeat (8) @(negedge clk);
      rd(2'd2, v);
      check(v == bad[b], "R3 stored control", v, bad[b]);
      check(!mem_req, "R3 no start", 32'(mem_req), 32'd0);
    end
    wr(2'd2, 32'd0);

    // R4 R5 R6 R7 sweep over counts and ready patterns
    for (int c = 1; c <= 6; c++)
      for (int m = 0; m < 3; m++)
        run_fill(24'h00_1000 + 24'(c * 64), 32'(c), m);

    // R4 upper counter bits ignored; R5 unaligned start wrapping below zero
    run_fill(24'h00_0003, 32'h0003_0002, 2);
    // R5 wrap through address zero
    run_fill(24'h00_0008, 32'd4, 2);
    // R6 count of one writes only the marker
    run_fill(24'hFF_FF00, 32'd1, 1);

    // R10 writes while running are ignored
    wr(2'd0, 32'h0000_4000);
    wr(2'd1, 32'd8);
    arm(24'h00_4000, 32'd8, 1);
    wr(2'd2, 32'h1100_0002);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_0123;
    @(negedge clk);
    reg_sel = 2'd1; reg_wdata = 32'd3;
    @(negedge clk);
    reg_wr_en = 1'b0;
    finish_job(24'h00_4000, 32'd8);

    // R9 R10 start write colliding with marker acceptance
    wr(2'd0, 32'h0000_2000);
    wr(2'd1, 32'd3);
    arm(24'h00_2000, 32'd3, 0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h1100_0002;
    repeat (5) @(negedge clk);
    reg_wr_en = 1'b0;
    finish_job(24'h00_2000, 32'd3);

    // R4 zero count means 65536 words
    run_fill(24'h01_0000, 32'hFFFF_0000, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule